// File: doc/BRIEF.md
# Serial Link Health Monitor

This block watches one received serial link and turns two per-cycle indications from the receiver, an error strobe and a "synchronised" level, into a health summary. It reports whether the link has been clean for long enough to trust, whether it has ever produced an error, and whether errors have piled up past a fault limit. It also keeps a running error count for diagnostics.

One instance serves one link; a chip with several links places one instance per link. A link enable of 0 holds the monitor cleared. A separate clear input lets software restart the monitor without touching the enable. Errors are counted only while the receiver reports sync. Before sync, the receiver output carries no meaning.

Top module: `lnk_health_mon`

## Requirements
- R1: After reset, `link_ok`, `link_err_seen` and `link_fault` are 0 and `err_cnt` is 0.
- R2: A cycle is clean when `sync_done`=1 and `rx_err`=0. `link_ok` becomes 1 in the cycle after the 15th consecutive clean rising edge (parameter STABLE_RUN=15), and not before.
- R3: An edge with a qualified error (`rx_err`=1 with `sync_done`=1), or with `sync_done`=0, restarts the clean run. `link_ok` is 0 in the following cycle.
- R4: `link_err_seen` becomes 1 after the first qualified error. It stays 1 until a clear.
- R5: `link_fault` becomes 1 after the 101st qualified error, which is more than FAULT_LIMIT=100. It is 0 after the 100th. It stays 1 until a clear.
- R6: `err_cnt` is an 8-bit count of qualified errors that increments by one per qualified error. It stops at 255 and never wraps.
- R7: `rx_err`=1 while `sync_done`=0 changes neither `err_cnt`, `link_err_seen` nor `link_fault`.
- R8: At any edge where `link_en`=0 or `mon_clr`=1, all state returns to the R1 values, whatever `rx_err` and `sync_done` are at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per crossing |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Link enable; 0 holds the monitor cleared |
| mon_clr | input | 1 | Synchronous software clear of the monitor |
| sync_done | input | 1 | Receiver reports it is synchronised |
| rx_err | input | 1 | Per-cycle receive error strobe |
| link_ok | output | 1 | Link has been clean for STABLE_RUN cycles |
| link_err_seen | output | 1 | Sticky: at least one qualified error |
| link_fault | output | 1 | Sticky: more than FAULT_LIMIT qualified errors |
| err_cnt | output | 8 | Saturating count of qualified errors |

## Verification
All outputs come straight from registers, so a wrong internal state shows at the ports one cycle after the edge that caused it.

- A run counter that is off by one moves the rise of `link_ok` by one cycle. Probing the 14th and 15th clean edges exposes it.
- A run counter that is not restarted keeps `link_ok` high in the cycle after an error.
- A tally that wraps or uses the wrong limit moves or drops `link_fault` around errors 100 and 101.
- A count that wraps shows 0 after the 256th error.

// File: rtl/lhm_pkg.sv
package lhm_pkg;

    // Per-cycle event decoded once at the top and shared by the sub-blocks.
    typedef struct packed {
        logic wipe;   // clear all monitor state at this edge
        logic qerr;   // error counted: strobe while synchronised
        logic clean;  // synchronised and error free
    } lhm_evt_t;

endpackage

// File: rtl/lhm_run_qual.sv
module lhm_run_qual
    import lhm_pkg::*;
#(
    parameter int STABLE_RUN = 15
) (
    input  logic     clk,
    input  logic     rst_n,
    input  lhm_evt_t evt,
    output logic     stable
);
    localparam int RUN_W = $clog2(STABLE_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STABLE_RUN);

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt.wipe || !evt.clean) begin
            st_d.run = '0;
        end else if (st_q.run != RUN_MAX) begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stable = (st_q.run == RUN_MAX);

endmodule

// File: rtl/lhm_err_tally.sv
module lhm_err_tally
    import lhm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int FAULT_LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lhm_evt_t         evt,
    output logic [CNT_W-1:0] err_cnt,
    output logic             err_seen,
    output logic             fault
);
    localparam int TALLY_W = $clog2(FAULT_LIMIT + 2);
    localparam logic [TALLY_W-1:0] TALLY_TOP = TALLY_W'(FAULT_LIMIT + 1);
    localparam logic [CNT_W-1:0]   CNT_TOP   = '1;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [TALLY_W-1:0] tally;
        logic               seen;
    } tally_st_t;

    tally_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt.wipe) begin
            st_d = '0;
        end else if (evt.qerr) begin
            st_d.seen = 1'b1;
            if (st_q.cnt != CNT_TOP)     st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.tally != TALLY_TOP) st_d.tally = st_q.tally + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_cnt  = st_q.cnt;
    assign err_seen = st_q.seen;
    assign fault    = (st_q.tally == TALLY_TOP);

endmodule

// File: rtl/lnk_health_mon.sv
module lnk_health_mon
    import lhm_pkg::*;
#(
    parameter int STABLE_RUN  = 15,
    parameter int FAULT_LIMIT = 100,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_en,
    input  logic             mon_clr,
    input  logic             sync_done,
    input  logic             rx_err,
    output logic             link_ok,
    output logic             link_err_seen,
    output logic             link_fault,
    output logic [CNT_W-1:0] err_cnt
);
    lhm_evt_t evt;

    always_comb begin
        evt.wipe  = !link_en || mon_clr;
        evt.qerr  = sync_done && rx_err;
        evt.clean = sync_done && !rx_err;
    end

    lhm_run_qual #(
        .STABLE_RUN(STABLE_RUN)
    ) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .stable(link_ok)
    );

    lhm_err_tally #(
        .CNT_W      (CNT_W),
        .FAULT_LIMIT(FAULT_LIMIT)
    ) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .err_cnt (err_cnt),
        .err_seen(link_err_seen),
        .fault   (link_fault)
    );

endmodule

// File: rtl/lhm_checker.sv
module lhm_checker #(
    parameter int CNT_W       = 8,
    parameter int FAULT_LIMIT = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_en,
    input logic             mon_clr,
    input logic             sync_done,
    input logic             rx_err,
    input logic             link_ok,
    input logic             link_err_seen,
    input logic             link_fault,
    input logic [CNT_W-1:0] err_cnt
);
    logic live;
    assign live = link_en && !mon_clr;

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_done || rx_err) |=> !link_ok);                              // R3

    AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_err_seen && live) |=> link_err_seen);                        // R4

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_fault && live) |=> link_fault);                              // R5

    AST_FAULT_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        link_fault |-> (err_cnt > CNT_W'(FAULT_LIMIT)));                   // R5

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == '1 && live) |=> (err_cnt == '1));                      // R6

    AST_NOSYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_done && live) |=> ($stable(err_cnt) && $stable(link_err_seen)
                                  && $stable(link_fault)));                // R7

    AST_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (err_cnt == '0 && !link_ok && !link_err_seen && !link_fault)); // R8

endmodule

bind lnk_health_mon lhm_checker #(
    .CNT_W      (CNT_W),
    .FAULT_LIMIT(FAULT_LIMIT)
) u_lhm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_en      (link_en),
    .mon_clr      (mon_clr),
    .sync_done    (sync_done),
    .rx_err       (rx_err),
    .link_ok      (link_ok),
    .link_err_seen(link_err_seen),
    .link_fault   (link_fault),
    .err_cnt      (err_cnt)
);

// File: tb/test_lnk_health_mon.sv
`timescale 1ns/100ps
module test_lnk_health_mon;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_en = 1'b1;
    logic       mon_clr = 1'b0;
    logic       sync_done = 1'b0;
    logic       rx_err = 1'b0;
    logic       link_ok, link_err_seen, link_fault;
    logic [7:0] err_cnt;

    always #2.5 clk = ~clk;

    lnk_health_mon i_lnk_health_mon (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .mon_clr(mon_clr),
        .sync_done(sync_done), .rx_err(rx_err), .link_ok(link_ok),
        .link_err_seen(link_err_seen), .link_fault(link_fault), .err_cnt(err_cnt)
    );

    typedef struct {
        logic       ok;
        logic       seen;
        logic       fault;
        logic [7:0] cnt;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    // reference model state
    int m_run = 0, m_cnt = 0, m_tally = 0;
    bit m_seen = 0;

    task automatic cmp(input exp_t e);
        n_vec++;
        if (link_ok !== e.ok || link_err_seen !== e.seen ||
            link_fault !== e.fault || err_cnt !== e.cnt) begin
            n_bad++;
            $display("FAIL %s: got ok=%b seen=%b fault=%b cnt=%0d exp ok=%b seen=%b fault=%b cnt=%0d",
                     e.tag, link_ok, link_err_seen, link_fault, err_cnt,
                     e.ok, e.seen, e.fault, e.cnt);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input bit en, input bit clr, input bit sy, input bit er,
                        input string tag);
        exp_t e;
        @(negedge clk);
        link_en = en; mon_clr = clr; sync_done = sy; rx_err = er;
        if (!en || clr) begin
            m_run = 0; m_cnt = 0; m_tally = 0; m_seen = 0;
        end else begin
            if (!sy || er) m_run = 0;
            else if (m_run < 15) m_run++;
            if (sy && er) begin
                m_seen = 1;
                if (m_cnt < 255) m_cnt++;
                if (m_tally < 101) m_tally++;
            end
        end
        e.ok = (m_run == 15); e.seen = m_seen; e.fault = (m_tally > 100);
        e.cnt = 8'(m_cnt); e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) cmp(q.pop_front());
        end
    end

    initial begin
        #(2000 * 5);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        #1;
        r.ok = 0; r.seen = 0; r.fault = 0; r.cnt = 0; r.tag = "R1 reset";
        cmp(r);
        rst_n = 1'b1;
        // R2: clean run qualifies after 15 edges
        for (int i = 0; i < 16; i++) step(1, 0, 1, 0, "R2 run");
        // R3 R4 R6: one error drops ok, sets sticky, counts
        step(1, 0, 1, 1, "R3 R4 R6 first error");
        for (int i = 0; i < 15; i++) step(1, 0, 1, 0, "R2 requalify");
        // R3: loss of sync restarts run
        step(1, 0, 0, 0, "R3 sync loss");
        // R7: errors without sync ignored
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, "R7 unsynced error");
        // R4 sticky across clean cycles
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, "R4 sticky");
        // R5: errors up to 100 then 101
        for (int i = 0; i < 98; i++) step(1, 0, 1, 1, "R5 below limit");
        step(1, 0, 1, 1, "R5 at 100");
        step(1, 0, 1, 1, "R5 at 101");
        step(1, 0, 1, 0, "R5 fault sticky");
        // R6: saturate count
        for (int i = 0; i < 160; i++) step(1, 0, 1, 1, "R6 saturate");
        step(1, 0, 0, 1, "R7 no change at 255");
        // R8: software clear overrides error
        step(1, 1, 1, 1, "R8 clear");
        for (int i = 0; i < 5; i++) step(1, 0, 1, 1, "R6 recount");
        // R8: enable low clears and holds
        step(0, 0, 1, 1, "R8 disable");
        step(0, 0, 1, 0, "R8 held");
        for (int i = 0; i < 16; i++) step(1, 0, 1, 0, "R2 after enable");
        wait (q.size() == 0);
        @(posedge clk); #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule